// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one hardware message cell shared by several requesters (threads). Behind a tag word it holds a short circular queue of 64-bit words. The tag carries empty, full and trap flags, a constant queue-type flag, the current fill count and a code for the queue depth. Every request names a view code. The view code decides how the access is treated:

- A control view reads and writes the tag directly.
- Two queue views push (on writes) or pop (on reads). One of them is blocking and the other is non-blocking.

A blocking access that cannot complete is not performed. The cell answers it with a retry status and remembers the requester in a waiter mask. Later, when a queue access completes, the cell emits that mask once on a wake output and then clears it. The surrounding system uses the wake output to rerun the parked threads. Suspending and resuming the threads themselves is done outside this block.

Each accepted request gets one response, one clock cycle later. The response carries the read data and the retry status.

Top module: `fifo_comm_cell`

## Requirements
- R1: After reset the tag reads as follows: E=1, F=0, T=0, fill count 0, queue-type flag 1, depth code log2(DEPTH). With the default depth this is 0x30020001.
- R2: A control-view read returns a tag word with this layout:
  - bits 31:28: depth code
  - from bit 18 upward: fill count
  - bit 17: queue-type flag
  - bit 16: T
  - bit 1: F
  - bit 0: E
  View codes: 1 = control, 2 = blocking queue, 3 = non-blocking queue.
- R3: A control-view write loads T, E and F from write-data bits 16, 0 and 1. If the new E is 1, the fill count is cleared. The read position is left unchanged.
- R4: Completed pushes and pops keep first-in first-out order, including when the read position wraps around the end of the storage.
- R5: A push that makes the fill count equal DEPTH sets F. A non-blocking push to a full queue stores nothing and leaves the fill count at DEPTH.
- R6: A pop that leaves the fill count at zero sets E. A non-blocking pop from an empty queue returns 0 without retry.
- R7: A queue-view read always clears F. A blocking read while E=1 answers with retry, pops nothing and records the requester in the waiter mask.
- R8: A queue-view write always clears E. A blocking write while F=1 answers with retry, stores nothing and records the requester in the waiter mask.
- R9: A completed queue access while the waiter mask is non-empty drives the mask on wake_mask for exactly one cycle and empties the mask. Otherwise wake_mask stays 0.
- R10: View codes other than 1, 2 and 3 read as all ones. A write with such a view code changes no state.
- R11: Each request is answered exactly one cycle after it is accepted, with rsp_valid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code (1 control, 2 blocking queue, 3 non-blocking queue) |
| req_id | input | ID_W | Requester number, selects waiter bit |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_retry | output | 1 | Blocking access could not complete |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| wake_mask | output | WAITERS | One-cycle pulse of the waiters to resume |

## Verification
The hardest states to reach are those where the flags disagree with the fill count, because normal pushes and pops keep the two consistent. One example is F set while entries remain below full. The stimulus reaches these states by forcing the flags through the control view and then issuing blocking queue accesses, so that a stall clears the opposite flag with no data movement. The bench also runs the queue round a full wrap with a partly drained starting point. It checks every popped word against a bench-side model of the queue.

// File: rtl/fcell_pkg.sv
package fcell_pkg;

    localparam logic [3:0] VIEW_CTRL = 4'd1;
    localparam logic [3:0] VIEW_WAIT = 4'd2;
    localparam logic [3:0] VIEW_TRY  = 4'd3;

    localparam int POS_DEPTH = 28;
    localparam int POS_CNT   = 18;
    localparam int POS_QTYPE = 17;
    localparam int POS_TRAP  = 16;
    localparam int POS_FULL  = 1;
    localparam int POS_EMPTY = 0;

    typedef struct packed {
        logic trap;
        logic empty;
        logic full;
    } cell_flags_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_QUEUE,
        ACC_BAD
    } acc_kind_e;

    function automatic logic [63:0] pack_tag(input logic [3:0] depth_code,
                                             input logic [7:0] count,
                                             input cell_flags_t fl);
        logic [63:0] w;
        w = '0;
        w[POS_DEPTH +: 4] = depth_code;
        w[POS_CNT +: 8]   = count;
        w[POS_QTYPE]      = 1'b1;
        w[POS_TRAP]       = fl.trap;
        w[POS_FULL]       = fl.full;
        w[POS_EMPTY]      = fl.empty;
        return w;
    endfunction

    function automatic acc_kind_e classify(input logic valid, input logic [3:0] view);
        if (!valid)                               return ACC_NONE;
        if (view == VIEW_CTRL)                    return ACC_CTRL;
        if (view == VIEW_WAIT || view == VIEW_TRY) return ACC_QUEUE;
        return ACC_BAD;
    endfunction

endpackage

// File: rtl/cell_store.sv
module cell_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              clear_cnt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0]  rd_pos;
    logic [IDX_W-1:0]  wr_pos;

    assign wr_pos = rd_pos + count[IDX_W-1:0];
    assign head   = slots[rd_pos];

    always_ff @(posedge clk) begin
        if (push) slots[wr_pos] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pos <= '0;
            count  <= '0;
        end else if (clear_cnt) begin
            count <= '0;
        end else if (pop) begin
            rd_pos <= rd_pos + 1'b1;
            count  <= count - 1'b1;
        end else if (push) begin
            count <= count + 1'b1;
        end
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_op_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, pop, clear_cnt}));
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
endmodule

// File: rtl/cell_waiters.sv
module cell_waiters #(
    parameter int WAITERS = 8,
    localparam int ID_W = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               add_en,
    input  logic [ID_W-1:0]    add_id,
    input  logic               flush,
    output logic [WAITERS-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)         mask <= '0;
        else if (flush)  mask <= '0;
        else if (add_en) mask <= mask | (WAITERS'(1) << add_id);
    end

    p_waiter_recorded_r7: assert property (@(posedge clk) disable iff (rst)
        add_en && !flush |=> mask[$past(add_id)]);
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> mask == '0);
endmodule

// File: rtl/fifo_comm_cell.sv
module fifo_comm_cell
    import fcell_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 64,
    parameter int WAITERS = 8,
    localparam int ID_W   = (WAITERS > 1) ? $clog2(WAITERS) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam logic [3:0] DEPTH_CODE = 4'($clog2(DEPTH))
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [3:0]         req_view,
    input  logic [ID_W-1:0]    req_id,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_retry,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [WAITERS-1:0] wake_mask
);
    cell_flags_t        flags;
    cell_flags_t        flags_nx;
    acc_kind_e          kind;
    logic               blocking;
    logic               stall;
    logic               done_q;
    logic               do_push;
    logic               do_pop;
    logic               clr_cnt;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   cnt_after;
    logic [DATA_W-1:0]  head;
    logic [WAITERS-1:0] waiters;
    logic [DATA_W-1:0]  rdata_nx;
    logic [63:0]        tag_word;

    assign kind     = classify(req_valid, req_view);
    assign blocking = (req_view == VIEW_WAIT);
    assign stall    = (kind == ACC_QUEUE) && blocking &&
                      (req_write ? flags.full : flags.empty);
    assign done_q   = (kind == ACC_QUEUE) && !stall;
    assign do_pop   = done_q && !req_write && (count != '0);
    assign do_push  = done_q && req_write && (count != CNT_W'(DEPTH));
    assign clr_cnt  = (kind == ACC_CTRL) && req_write && req_wdata[POS_EMPTY];
    assign tag_word = pack_tag(DEPTH_CODE, 8'(count), flags);

    always_comb begin
        cnt_after = count;
        if (do_pop)  cnt_after = count - 1'b1;
        if (do_push) cnt_after = count + 1'b1;
    end

    always_comb begin
        flags_nx = flags;
        if (kind == ACC_CTRL && req_write) begin
            flags_nx.trap  = req_wdata[POS_TRAP];
            flags_nx.empty = req_wdata[POS_EMPTY];
            flags_nx.full  = req_wdata[POS_FULL];
        end else if (kind == ACC_QUEUE && !req_write) begin
            flags_nx.full = 1'b0;
            if (!stall && cnt_after == '0) flags_nx.empty = 1'b1;
        end else if (kind == ACC_QUEUE && req_write) begin
            flags_nx.empty = 1'b0;
            if (!stall && cnt_after == CNT_W'(DEPTH)) flags_nx.full = 1'b1;
        end
    end

    always_comb begin
        rdata_nx = '0;
        if (!req_write) begin
            unique case (kind)
                ACC_CTRL:  rdata_nx = DATA_W'(tag_word);
                ACC_QUEUE: rdata_nx = do_pop ? head : '0;
                ACC_BAD:   rdata_nx = '1;
                default:   rdata_nx = '0;
            endcase
        end
    end

    cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
        .clear_cnt(clr_cnt), .wdata(req_wdata), .head(head), .count(count)
    );

    cell_waiters #(.WAITERS(WAITERS)) u_wait (
        .clk(clk), .rst(rst), .add_en(stall), .add_id(req_id),
        .flush(done_q && (waiters != '0)), .mask(waiters)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '{trap: 1'b0, empty: 1'b1, full: 1'b0};
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_rdata <= '0;
            wake_mask <= '0;
        end else begin
            flags     <= flags_nx;
            rsp_valid <= req_valid;
            rsp_retry <= stall;
            rsp_rdata <= rdata_nx;
            wake_mask <= done_q ? waiters : '0;
        end
    end

    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_single_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_retry_only_blocking_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_retry |-> $past(req_view) == VIEW_WAIT);
    p_wake_single_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_mask != '0) |=> wake_mask == '0);
    p_full_set_r5: assert property (@(posedge clk) disable iff (rst)
        do_push && count == CNT_W'(DEPTH - 1) |=> flags.full);
    p_empty_set_r6: assert property (@(posedge clk) disable iff (rst)
        do_pop && count == CNT_W'(1) |=> flags.empty);
endmodule

// File: tb/sim_fifo_comm_cell.sv
module sim_fifo_comm_cell;
    localparam int DEPTH = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [3:0]  req_view = 0;
    logic [2:0]  req_id = 0;
    logic [63:0] req_wdata = 0;
    logic        rsp_valid;
    logic        rsp_retry;
    logic [63:0] rsp_rdata;
    logic [7:0]  wake_mask;

    int checks = 0;
    int fails  = 0;

    logic        s_valid, s_retry;
    logic [63:0] s_data;
    logic [7:0]  s_wake;

    logic [63:0] mq [DEPTH];
    int mrd = 0, mptr = 0;
    logic mt = 0, me = 1, mf = 0;

    always #2.5 clk = ~clk;

    fifo_comm_cell u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .wake_mask(wake_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_tag(input int p, input logic t,
                                            input logic e, input logic f);
        return (64'(3) << 28) | (64'(p) << 18) | (64'(1) << 17) |
               (64'(t) << 16) | (64'(f) << 1) | 64'(e);
    endfunction

    function automatic logic [63:0] pat(input int k);
        return 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h0101_0101_0101_0101);
    endfunction

    task automatic req(input logic w, input logic [3:0] v, input logic [2:0] id,
                       input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_view = v; req_id = id; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        s_valid = rsp_valid; s_retry = rsp_retry; s_data = rsp_rdata; s_wake = wake_mask;
    endtask

    task automatic tag_check(input string tag);
        req(0, 4'd1, 0, 0);
        chk(tag, s_data, exp_tag(mptr, mt, me, mf));
    endtask

    task automatic push(input logic [3:0] v, input logic [63:0] d, input logic [7:0] ew);
        req(1, v, 0, d);
        chk("R9 wake on push", 64'(s_wake), 64'(ew));
        chk("R8 no retry push", 64'(s_retry), 0);
        me = 0;
        if (mptr < DEPTH) begin mq[(mrd + mptr) % DEPTH] = d; mptr++; end
        if (mptr == DEPTH) mf = 1;
    endtask

    task automatic pop(input logic [3:0] v, input logic [7:0] ew);
        logic [63:0] e;
        e = 0;
        req(0, v, 0, 0);
        mf = 0;
        if (mptr > 0) begin e = mq[mrd]; mrd = (mrd + 1) % DEPTH; mptr--; end
        if (mptr == 0) me = 1;
        chk("R4 pop data", s_data, e);
        chk("R9 wake on pop", 64'(s_wake), 64'(ew));
        chk("R6 no retry pop", 64'(s_retry), 0);
    endtask

    task automatic ctrl_wr(input logic t, input logic e, input logic f);
        req(1, 4'd1, 0, (64'(t) << 16) | (64'(f) << 1) | 64'(e));
        mt = t; me = e; mf = f;
        if (e) mptr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tag_check("R1 reset tag");
        chk("R11 rsp valid", 64'(s_valid), 1);
        @(negedge clk);
        chk("R11 rsp single", 64'(rsp_valid), 0);

        req(0, 4'd3, 0, 0);
        chk("R6 try pop empty data", s_data, 0);
        chk("R6 try pop empty retry", 64'(s_retry), 0);
        tag_check("R6 empty tag");

        req(0, 4'd2, 3'd2, 0);
        chk("R7 blocking pop retry", 64'(s_retry), 1);
        tag_check("R7 tag after stall");
        push(4'd3, pat(0), 8'h04);
        tag_check("R2 tag one entry");

        for (int k = 1; k < DEPTH; k++) push(4'd3, pat(k), 8'h00);
        tag_check("R5 full tag");
        push(4'd3, 64'hDEAD, 8'h00);
        tag_check("R5 dropped push");

        req(1, 4'd2, 3'd5, 64'hBEEF);
        chk("R8 blocking push retry", 64'(s_retry), 1);
        tag_check("R8 tag after stall");

        pop(4'd2, 8'h20);
        for (int k = 1; k < DEPTH; k++) pop(4'd2, 8'h00);
        tag_check("R6 empty after drain");

        for (int k = 0; k < 3; k++) push(4'd2, pat(10 + k), 8'h00);
        for (int k = 0; k < 3; k++) pop(4'd3, 8'h00);
        for (int k = 0; k < DEPTH; k++) push(4'd3, pat(20 + k), 8'h00);
        tag_check("R4 wrapped full tag");
        for (int k = 0; k < DEPTH - 2; k++) pop(4'd3, 8'h00);

        ctrl_wr(1, 0, 1);
        mptr = 2;
        tag_check("R3 flags loaded count kept");
        pop(4'd3, 8'h00);
        tag_check("R7 read clears F");
        ctrl_wr(0, 1, 0);
        tag_check("R3 E clears count");

        req(0, 4'd0, 0, 0);
        chk("R10 bad view read", s_data, 64'hFFFF_FFFF_FFFF_FFFF);
        req(0, 4'd7, 0, 0);
        chk("R10 bad view 7 read", s_data, 64'hFFFF_FFFF_FFFF_FFFF);
        req(1, 4'd4, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        tag_check("R10 bad view write ignored");

        ctrl_wr(0, 1, 1);
        req(1, 4'd2, 3'd1, 64'h55);
        chk("R8 stall retry flags forced", 64'(s_retry), 1);
        me = 0;
        tag_check("R8 stall clears E");
        push(4'd3, 64'h77, 8'h02);
        tag_check("R5 F kept below depth");

        ctrl_wr(1, 1, 1);
        req(0, 4'd2, 3'd6, 0);
        chk("R7 stall with F", 64'(s_retry), 1);
        mf = 0;
        tag_check("R7 stall clears F");
        pop(4'd3, 8'h40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule